// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds the eight extended-precision data registers of a floating-point unit and presents them as a stack. A rotating top-of-stack pointer selects which physical register answers to ST(0); every other stack position ST(i) is reached relative to it. An arithmetic datapath beside the block reads its operands through read commands, hands results back through write commands, and uses push and pop to load and retire values. Data crosses the boundary as raw 80-bit words; arithmetic and format conversion happen elsewhere.

Each physical register carries a 2-bit tag that classifies its content, so the block can spot a push into an occupied slot (stack overflow) and any use of an empty slot (stack underflow) without inspecting data. A faulting command changes no register, no tag and no pointer; it only reports the fault in its response and sets sticky bits in the status word, where the pointer is also visible.

Commands enter on a valid/ready channel and each accepted command yields exactly one response on a second valid/ready channel. The response sits in a single output register: while a response is pending and the consumer holds `rsp_ready` low, `cmd_ready` is low and no further command is taken; when `rsp_ready` is high a new command may be accepted in the same cycle the pending response is consumed. A response appears the cycle after its command is accepted.

Top module: `fstk_top`

## Requirements
- R1: After reset every tag reads empty (`tag_word` all ones), the pointer is 0, `status_word` bits [2:0] are 0, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: ST(i) is physical register (TOP + i) mod 8. A push (op 0) decrements TOP modulo 8 and writes `cmd_data` into the new ST(0); TOP is `status_word[10:8]`.
- R3: A written word is tagged from its bits (exponent [78:64], significand [63:0]): 01 zero when exponent and significand are both 0; 10 special when the exponent is all ones, the exponent is 0, or significand bit 63 is 0; otherwise 00 valid. 11 means empty. Physical register k's tag is `tag_word[2k+1:2k]`.
- R4: A pop (op 1) returns ST(0)'s data and tag, marks that slot empty and increments TOP.
- R5: A read (op 2) returns ST(`cmd_idx`)'s data and tag and changes nothing.
- R6: A write (op 3) replaces ST(`cmd_idx`) with `cmd_data`, tags it per R3 and leaves TOP unchanged.
- R7: A write-then-pop (op 4) stores `cmd_data` into ST(1), empties ST(0) and increments TOP, so the stored word becomes the new ST(0).
- R8: A push when ST(-1) (physical TOP-1) is not empty is an overflow: response has `rsp_fault`=1 and `rsp_over`=1, no state changes, and sticky `status_word[1]` (overflow) and `[2]` (stack fault) are set until reset.
- R9: A pop or write-then-pop with ST(0) or (for op 4) ST(1) empty, or a read of an empty ST(i), is an underflow: `rsp_fault`=1, `rsp_over`=0, no state changes, sticky `status_word[0]` and `[2]` set.
- R10: Each accepted command gives one response the next cycle; a pending response is held unchanged while `rsp_ready` is 0, and `cmd_ready` equals `!rsp_valid || rsp_ready`.
- R11: TOP wraps: eight pushes from reset fill the stack (TOP back to 0, all tags non-empty) and a ninth push overflows.
- R12: Responses of successful push, write and write-then-pop carry data 0 and the tag of the written word; faulting commands and reserved op codes 5 to 7 carry data 0 and tag 11, and reserved codes change nothing and raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command will be taken this cycle |
| cmd_op | input | 3 | 0 push, 1 pop, 2 read, 3 write, 4 write ST(1) then pop, 5-7 reserved |
| cmd_idx | input | 3 | Stack position i for read and write |
| cmd_data | input | 80 | Word for push, write and write-then-pop |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 80 | Data from pop or read, else 0 |
| rsp_tag | output | 2 | Tag of the slot read or word written, 11 on fault |
| rsp_fault | output | 1 | Command hit a stack fault |
| rsp_over | output | 1 | Fault was an overflow (0 means underflow) |
| status_word | output | 16 | [10:8] TOP, [2] stack fault, [1] overflow, [0] underflow |
| tag_word | output | 16 | Two tag bits per physical register |

## Verification
The bench aims at pointer wrap-around, where a design that handled TOP without modulo arithmetic would address the wrong register after the eighth push or flag a false fault. It drives underflow on pops, reads of an unused position and a write-then-pop with only one entry, where a faulty design would still move TOP or clear a tag. It stalls the response channel to catch a design that drops or overwrites a pending response, and checks each tag class so a misclassifier shows up as a wrong `rsp_tag`.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_WRPOP = 3'd4
  } op_e;

  localparam int unsigned STAT_W       = 16;
  localparam int unsigned STAT_UNF_BIT = 0;
  localparam int unsigned STAT_OVF_BIT = 1;
  localparam int unsigned STAT_FLT_BIT = 2;
  localparam int unsigned STAT_TOP_LSB = 8;

endpackage

// File: rtl/fstk_classify.sv
module fstk_classify
  import fstk_pkg::*;
#(
  parameter int unsigned WIDTH = 80,
  parameter int unsigned EXP_W = 15
) (
  input  logic [WIDTH-1:0] word,
  output tag_e             tag
);
  localparam int unsigned MAN_W = WIDTH - 1 - EXP_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] sig;

  assign expo = word[WIDTH-2 -: EXP_W];
  assign sig  = word[MAN_W-1:0];

  always_comb begin
    if (expo == '0 && sig == '0)
      tag = TAG_ZERO;
    else if (expo == '1 || expo == '0 || !sig[MAN_W-1])
      tag = TAG_SPECIAL;
    else
      tag = TAG_VALID;
  end

endmodule

// File: rtl/fstk_ptr.sv
module fstk_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_en,
  input  logic          inc_en,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] top,
  output logic [AW-1:0] top_m1,
  output logic [AW-1:0] top_p1,
  output logic [AW-1:0] top_pi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      top <= '0;
    else if (dec_en)
      top <= top - 1'b1;
    else if (inc_en)
      top <= top + 1'b1;
  end

  assign top_m1 = top - 1'b1;
  assign top_p1 = top + 1'b1;
  assign top_pi = top + idx;

endmodule

// File: rtl/fstk_regs.sv
module fstk_regs
  import fstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 80,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  tag_e             wr_tag,
  input  logic             kill_en,
  input  logic [AW-1:0]    kill_addr,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [2*DEPTH-1:0] tags
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic hit_wr, hit_kill;
    assign hit_wr   = wr_en && (wr_addr == AW'(k));
    assign hit_kill = kill_en && (kill_addr == AW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[k] <= '0;
      else if (hit_wr)
        mem[k] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tags[2*k +: 2] <= TAG_EMPTY;
      else if (hit_wr)
        tags[2*k +: 2] <= wr_tag;
      else if (hit_kill)
        tags[2*k +: 2] <= TAG_EMPTY;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fstk_top.sv
module fstk_top
  import fstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 80,
  parameter int unsigned EXP_W = 15,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [AW-1:0]      cmd_idx,
  input  logic [WIDTH-1:0]   cmd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [WIDTH-1:0]   rsp_data,
  output logic [1:0]         rsp_tag,
  output logic               rsp_fault,
  output logic               rsp_over,
  output logic [15:0]        status_word,
  output logic [2*DEPTH-1:0] tag_word
);
  logic          accept;
  logic [AW-1:0] top, a_m1, a_p1, a_i, rd_addr;
  tag_e          t_top, t_m1, t_p1, t_i, wr_class;
  logic [WIDTH-1:0] rd_data;

  logic          wr_en, kill_en, dec_en, inc_en;
  logic [AW-1:0] wr_addr;
  logic          n_fault, n_over;
  logic [WIDTH-1:0] n_data;
  tag_e          n_tag;
  logic          ovf_q, unf_q;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;

  fstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .inc_en(inc_en),
    .idx(cmd_idx), .top(top), .top_m1(a_m1), .top_p1(a_p1), .top_pi(a_i)
  );

  fstk_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cls (
    .word(cmd_data), .tag(wr_class)
  );

  fstk_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(cmd_data), .wr_tag(wr_class),
    .kill_en(kill_en), .kill_addr(top),
    .rd_addr(rd_addr), .rd_data(rd_data), .tags(tag_word)
  );

  assign t_top = tag_e'(tag_word[2*top +: 2]);
  assign t_m1  = tag_e'(tag_word[2*a_m1 +: 2]);
  assign t_p1  = tag_e'(tag_word[2*a_p1 +: 2]);
  assign t_i   = tag_e'(tag_word[2*a_i +: 2]);
  assign rd_addr = (cmd_op == OP_POP) ? top : a_i;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = a_i;
    kill_en = 1'b0;
    dec_en  = 1'b0;
    inc_en  = 1'b0;
    n_fault = 1'b0;
    n_over  = 1'b0;
    n_data  = '0;
    n_tag   = TAG_EMPTY;
    if (accept) begin
      case (cmd_op)
        OP_PUSH: begin
          if (t_m1 != TAG_EMPTY) begin
            n_fault = 1'b1;
            n_over  = 1'b1;
          end else begin
            wr_en   = 1'b1;
            wr_addr = a_m1;
            dec_en  = 1'b1;
            n_tag   = wr_class;
          end
        end
        OP_POP: begin
          if (t_top == TAG_EMPTY) begin
            n_fault = 1'b1;
          end else begin
            kill_en = 1'b1;
            inc_en  = 1'b1;
            n_data  = rd_data;
            n_tag   = t_top;
          end
        end
        OP_READ: begin
          if (t_i == TAG_EMPTY) begin
            n_fault = 1'b1;
          end else begin
            n_data = rd_data;
            n_tag  = t_i;
          end
        end
        OP_WRITE: begin
          wr_en   = 1'b1;
          wr_addr = a_i;
          n_tag   = wr_class;
        end
        OP_WRPOP: begin
          if (t_top == TAG_EMPTY || t_p1 == TAG_EMPTY) begin
            n_fault = 1'b1;
          end else begin
            wr_en   = 1'b1;
            wr_addr = a_p1;
            kill_en = 1'b1;
            inc_en  = 1'b1;
            n_tag   = wr_class;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= TAG_EMPTY;
      rsp_fault <= 1'b0;
      rsp_over  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= n_data;
      rsp_tag   <= n_tag;
      rsp_fault <= n_fault;
      rsp_over  <= n_over;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (n_fault && n_over)  ovf_q <= 1'b1;
      if (n_fault && !n_over) unf_q <= 1'b1;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[STAT_UNF_BIT] = unf_q;
    status_word[STAT_OVF_BIT] = ovf_q;
    status_word[STAT_FLT_BIT] = unf_q | ovf_q;
    status_word[STAT_TOP_LSB +: AW] = top;
  end

endmodule

// File: rtl/fstk_chk.sv
module fstk_chk
  import fstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 80,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2:0]         cmd_op,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [WIDTH-1:0]   rsp_data,
  input logic [1:0]         rsp_tag,
  input logic               rsp_fault,
  input logic               rsp_over,
  input logic [15:0]        status_word,
  input logic [2*DEPTH-1:0] tag_word
);
  logic [AW-1:0] top_q;
  logic          acc;
  assign top_q = status_word[STAT_TOP_LSB +: AW];
  assign acc   = cmd_valid && cmd_ready;

  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_fault))); // R10

  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R10

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_PUSH) |=> (rsp_fault || (top_q + 1'b1) == $past(top_q))); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == OP_POP || cmd_op == OP_WRPOP)) |=> (rsp_fault || top_q == ($past(top_q) + 1'b1))); // R4

  AST_NO_OVF_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((rsp_fault && rsp_over) -> (tag_word == $past(tag_word) && top_q == $past(top_q)))); // R8

  AST_NO_UNF_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((rsp_fault && !rsp_over) -> (tag_word == $past(tag_word) && top_q == $past(top_q)))); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[STAT_FLT_BIT] |=> status_word[STAT_FLT_BIT]); // R8

endmodule

bind fstk_top fstk_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_fault(rsp_fault),
  .rsp_over(rsp_over), .status_word(status_word), .tag_word(tag_word)
);

// File: tb/sim_fstk_top.sv
`timescale 1ns/1ps
module sim_fstk_top;
  localparam logic [79:0] W_ONE  = 80'h3FFF_8000000000000000;
  localparam logic [79:0] W_TWO  = 80'h4000_8000000000000000;
  localparam logic [79:0] W_ZRO  = 80'h0;
  localparam logic [79:0] W_INF  = 80'h7FFF_8000000000000000;
  localparam logic [79:0] W_DEN  = 80'h0000_0000000000000001;
  localparam logic [79:0] W_NEG3 = 80'hC000_C000000000000000;
  localparam logic [79:0] W_UNN  = 80'h3FFF_4000000000000000;
  localparam int VW = 173;
  localparam int NV = 18;

  // {op, idx, din, exp_fault, exp_over, exp_tag, exp_data, exp_top}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 3'd0, W_ONE,  1'b0, 1'b0, 2'b00, 80'h0,  3'd7},
    {3'd0, 3'd0, W_TWO,  1'b0, 1'b0, 2'b00, 80'h0,  3'd6},
    {3'd0, 3'd0, W_ZRO,  1'b0, 1'b0, 2'b01, 80'h0,  3'd5},
    {3'd2, 3'd1, 80'h0,  1'b0, 1'b0, 2'b00, W_TWO,  3'd5},
    {3'd2, 3'd2, 80'h0,  1'b0, 1'b0, 2'b00, W_ONE,  3'd5},
    {3'd2, 3'd3, 80'h0,  1'b1, 1'b0, 2'b11, 80'h0,  3'd5},
    {3'd3, 3'd0, W_INF,  1'b0, 1'b0, 2'b10, 80'h0,  3'd5},
    {3'd2, 3'd0, 80'h0,  1'b0, 1'b0, 2'b10, W_INF,  3'd5},
    {3'd4, 3'd0, W_NEG3, 1'b0, 1'b0, 2'b00, 80'h0,  3'd6},
    {3'd2, 3'd0, 80'h0,  1'b0, 1'b0, 2'b00, W_NEG3, 3'd6},
    {3'd1, 3'd0, 80'h0,  1'b0, 1'b0, 2'b00, W_NEG3, 3'd7},
    {3'd1, 3'd0, 80'h0,  1'b0, 1'b0, 2'b00, W_ONE,  3'd0},
    {3'd1, 3'd0, 80'h0,  1'b1, 1'b0, 2'b11, 80'h0,  3'd0},
    {3'd0, 3'd0, W_DEN,  1'b0, 1'b0, 2'b10, 80'h0,  3'd7},
    {3'd4, 3'd0, W_ONE,  1'b1, 1'b0, 2'b11, 80'h0,  3'd7},
    {3'd0, 3'd0, W_UNN,  1'b0, 1'b0, 2'b10, 80'h0,  3'd6},
    {3'd2, 3'd1, 80'h0,  1'b0, 1'b0, 2'b10, W_DEN,  3'd6},
    {3'd7, 3'd0, W_ONE,  1'b0, 1'b0, 2'b11, 80'h0,  3'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [79:0] rsp_data;
  logic [1:0]  rsp_tag;
  logic        rsp_fault, rsp_over;
  logic [15:0] status_word;
  logic [15:0] tag_word;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fstk_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_tag(rsp_tag), .rsp_fault(rsp_fault), .rsp_over(rsp_over),
    .status_word(status_word), .tag_word(tag_word)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one command with rsp_ready high; returns at the negedge after acceptance.
  task automatic issue(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_idx   = idx;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [2:0] op, input logic f, input logic o);
    if (f && o) return "R8";
    if (f)      return "R9";
    case (op)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(tag_word == 16'hFFFF, "R1", 96'(tag_word), 96'hFFFF);
    check(status_word[10:8] == 3'd0 && status_word[2:0] == 3'd0, "R1", 96'(status_word), 96'h0);
    check(!rsp_valid && cmd_ready, "R1", 96'({rsp_valid, cmd_ready}), 96'h1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      string rq;
      e = VEC[v];
      issue(e[172:170], e[169:167], e[166:87]);
      rq = req_of(e[172:170], e[86], e[85]);
      check(rsp_valid, "R10", 96'(rsp_valid), 96'h1);
      check(rsp_fault == e[86] && rsp_over == e[85], rq, 96'({rsp_fault, rsp_over}), 96'({e[86], e[85]}));
      check(rsp_tag == e[84:83], "R3", 96'(rsp_tag), 96'(e[84:83]));
      check(rsp_data == e[82:3], rq, 96'(rsp_data), 96'(e[82:3]));
      check(status_word[10:8] == e[2:0], rq, 96'(status_word[10:8]), 96'(e[2:0]));
    end
    // sticky flags after table: underflow seen, no overflow
    check(status_word[2:0] == 3'b101, "R9", 96'(status_word[2:0]), 96'h5);
    // R6 write left tags: phys6 special (UNN), phys7 special (DEN), others empty
    check(tag_word == 16'hAFFF, "R6", 96'(tag_word), 96'hAFFF);

    // R11 wrap: eight pushes then overflow
    do_reset();
    for (int k = 0; k < 8; k++) begin
      issue(3'd0, 3'd0, {16'h3FFF, 1'b1, 63'(k + 1)});
      check(!rsp_fault && status_word[10:8] == 3'(8 - k - 1), "R11",
            96'(status_word[10:8]), 96'(3'(8 - k - 1)));
    end
    check(tag_word == 16'h0000, "R11", 96'(tag_word), 96'h0);
    issue(3'd0, 3'd0, W_TWO);
    check(rsp_fault && rsp_over, "R8", 96'({rsp_fault, rsp_over}), 96'h3);
    check(status_word[10:8] == 3'd0 && tag_word == 16'h0000, "R8", 96'({status_word[10:8], tag_word}), 96'h0);
    check(status_word[2:0] == 3'b110, "R8", 96'(status_word[2:0]), 96'h6);
    for (int i = 0; i < 8; i++) begin
      issue(3'd2, 3'(i), 80'h0);
      check(rsp_data == {16'h3FFF, 1'b1, 63'(8 - i)}, "R11", 96'(rsp_data),
            96'({16'h3FFF, 1'b1, 63'(8 - i)}));
    end

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_idx = 3'd0; cmd_data = '0;
    @(negedge clk);
    cmd_op = 3'd1;
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid && !cmd_ready, "R10", 96'({rsp_valid, cmd_ready}), 96'h2);
      check(rsp_data == {16'h3FFF, 1'b1, 63'(8)} && status_word[10:8] == 3'd0, "R10",
            96'(rsp_data), 96'({16'h3FFF, 1'b1, 63'(8)}));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid && status_word[10:8] == 3'd1, "R10", 96'(status_word[10:8]), 96'h1);
    check(tag_word[1:0] == 2'b11, "R4", 96'(tag_word[1:0]), 96'h3);
    @(negedge clk);
    check(!rsp_valid, "R10", 96'(rsp_valid), 96'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule